// File: doc/BRIEF.md
# Serial Step-Attenuator Control Port

This block is the write-only control port of an RF receiver front end. A host drives three wires: an active-low frame select, a serial clock and a serial data line. The block samples all three in the system clock domain and shifts one bit in on each rising edge of the serial clock. The frame is 16 bits long and arrives most significant bit first. Its first byte is the address byte, which holds the path-select and enable bits. Its second byte is the data byte, which holds the attenuator code.

The shifted frame moves into the active control registers only when the frame select returns high after exactly 16 serial clocks. A frame that is too short or too long is thrown away. A protect input, when high, freezes the three address-byte control bits; attenuation updates still pass. A standby pin is combined with the stored enable bit to give the power-down output. Attenuation codes larger than the 25.5 dB maximum are clamped before they reach the output.

Top module: `serial_atten_ctrl`

## Requirements
- R1: While `ser_csn` is low, one bit of `ser_dat` is taken on each rising edge of `ser_clk`, most significant bit first. Frame bits 15..8 form the address byte A7..A0 and bits 7..0 form the data byte D7..D0. Serial clock edges seen while `ser_csn` is high have no effect.
- R2: The frame is committed when `ser_csn` rises, but only if exactly 16 serial clock edges arrived since it fell. With 15 or fewer edges, or with 17 or more, every output keeps its value.
- R3: `atten_code` takes data bits D6..D1, where D6 is worth 16 dB and D1 is worth 0.5 dB, and a 1 inserts that step. D7 and D0 have no effect. For example, data 0x80 and 0x01 give code 0, and data 0xE6 gives code 51.
- R4: A code above 51 (25.5 dB) is replaced by 51. Codes 0 to 51 pass through unchanged.
- R5: Address bit A2 sets `rf_sel_y` (1 selects input Y). A1 sets `lo_sel_b` (1 selects LO B). A0 sets `en_n` (1 turns the path off). A7..A3 have no effect.
- R6: If `prot_lock` is high at commit, `rf_sel_y`, `lo_sel_b` and `en_n` keep their previous values while `atten_code` is still written. If it is low, all fields are written.
- R7: `pwr_down` is high whenever `en_n` is high or `stby_pin` is high.
- R8: After reset, `atten_code` is 51 and `rf_sel_y`, `lo_sel_b` and `en_n` are 0.
- R9: The control outputs change only in the cycle after a valid commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_csn | input | 1 | Active-low frame select (asynchronous) |
| prot_lock | input | 1 | When high, freezes the address-byte control bits at commit |
| stby_pin | input | 1 | Standby request, active high |
| atten_code | output | 6 | Attenuator code in 0.5 dB units |
| rf_sel_y | output | 1 | RF input select, 1 = input Y |
| lo_sel_b | output | 1 | LO input select, 1 = LO B |
| en_n | output | 1 | Stored active-low path enable |
| pwr_down | output | 1 | Power-down output |

## Verification
The hardest cases are frames whose length is off by one in either direction, and serial clock activity while the frame select is idle. Each of these has to leave every output unchanged, so it can only be seen as the absence of an update. The stimulus first programs a known non-default state, then sends 15-edge and 17-edge frames that carry different values, then toggles the serial clock and data with the select high. After each of these it compares every output against the state held before. A correct 16-edge frame then follows, which shows that the discarded frames left no bit count behind.

// File: rtl/sac_pkg.sv
// Shared types and constants for the serial attenuator control port.
// Assumes a 6-bit attenuator code in 0.5 dB units with a 25.5 dB ceiling.
package sac_pkg;
    localparam int ATT_W   = 6;
    localparam int ATT_MAX = 51;

    typedef struct packed {
        logic [ATT_W-1:0] atten;
        logic             rf_y;
        logic             lo_b;
        logic             en_n;
    } ctl_t;

    // Clamp a raw attenuator code to the legal maximum.
    function automatic logic [ATT_W-1:0] clamp_atten(input logic [ATT_W-1:0] raw);
        if (raw > ATT_W'(ATT_MAX)) return ATT_W'(ATT_MAX);
        return raw;
    endfunction
endpackage

// File: rtl/sac_sync_edge.sv
// Multi-bit synchronizer with rising-edge detection.
// Each bit is an independent asynchronous level. Every bit passes through a
// STAGES-deep flop chain, so bits that were stable together stay aligned.
module sac_sync_edge #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_d;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = lvl[g] & ~lvl_d[g];

        assert_rise_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= RST_VAL;
        else        lvl_d <= lvl;
    end
endmodule

// File: rtl/sac_frame_shift.sv
// Serial frame shifter and length checker.
// Takes one bit per shift strobe while the select is active, and counts the
// strobes, saturating one past the frame length. A commit strobe is raised on
// the select's rising edge only when exactly FRAME_BITS strobes arrived.
module sac_frame_shift #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  din,
    input  logic                  csn_lvl,
    input  logic                  csn_rise,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  commit
);
    localparam int CNT_MAX = FRAME_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] sr;

    // Shift data and count edges during a frame; clear the count while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sr  <= '0;
        end else if (csn_lvl) begin
            cnt <= '0;
        end else if (shift_en) begin
            sr <= {sr[FRAME_BITS-2:0], din};
            if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
    end

    assign frame  = sr;
    assign commit = csn_rise && (cnt == CNT_W'(FRAME_BITS));

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CNT_MAX));
    assert_clear_after_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt == '0));
endmodule

// File: rtl/sac_commit_regs.sv
// Active control register bank.
// Decodes a committed frame: the data byte feeds the clamped attenuator code
// and address bits [2:0] feed the select and enable bits unless protected.
// Resets to maximum attenuation, input X, LO A, enabled.
module sac_commit_regs
    import sac_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic                  prot,
    input  logic [FRAME_BITS-1:0] frame,
    output ctl_t                  ctl
);
    localparam int ADDR_LSB = FRAME_BITS - 8;

    logic [7:0]       data_byte;
    logic [2:0]       addr_ctl;
    logic [ATT_W-1:0] code_next;

    assign data_byte = frame[7:0];
    assign addr_ctl  = frame[ADDR_LSB+2:ADDR_LSB];
    assign code_next = clamp_atten(data_byte[ATT_W:1]);

    // Load the active fields on a valid commit, honouring the protect input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.atten <= ATT_W'(ATT_MAX);
            ctl.rf_y  <= 1'b0;
            ctl.lo_b  <= 1'b0;
            ctl.en_n  <= 1'b0;
        end else if (commit) begin
            ctl.atten <= code_next;
            if (!prot) begin
                ctl.rf_y <= addr_ctl[2];
                ctl.lo_b <= addr_ctl[1];
                ctl.en_n <= addr_ctl[0];
            end
        end
    end

    assert_atten_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.atten <= ATT_W'(ATT_MAX));
    assert_protect_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && prot) |=> ($stable(ctl.rf_y) && $stable(ctl.lo_b) && $stable(ctl.en_n)));
    assert_no_change_without_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctl));
endmodule

// File: rtl/serial_atten_ctrl.sv
// Top level of the serial attenuator control port.
// Synchronizes the three serial wires and the protect input, checks the
// frame length, commits valid frames and forms the power-down output.
// Assumes each serial clock phase lasts at least three system clocks.
module serial_atten_ctrl
    import sac_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_csn,
    input  logic             prot_lock,
    input  logic             stby_pin,
    output logic [ATT_W-1:0] atten_code,
    output logic             rf_sel_y,
    output logic             lo_sel_b,
    output logic             en_n,
    output logic             pwr_down
);
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_CSN = 2;
    localparam int IDX_PRT = 3;

    logic [3:0]            s_lvl;
    logic [3:0]            s_rise;
    logic [FRAME_BITS-1:0] frame;
    logic                  commit;
    logic                  shift_en;
    ctl_t                  ctl;

    sac_sync_edge #(
        .W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({prot_lock, ser_csn, ser_dat, ser_clk}),
        .lvl(s_lvl), .rise(s_rise)
    );

    assign shift_en = s_rise[IDX_CLK] & ~s_lvl[IDX_CSN];

    sac_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_en(shift_en), .din(s_lvl[IDX_DAT]),
        .csn_lvl(s_lvl[IDX_CSN]), .csn_rise(s_rise[IDX_CSN]),
        .frame(frame), .commit(commit)
    );

    sac_commit_regs #(.FRAME_BITS(FRAME_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .prot(s_lvl[IDX_PRT]),
        .frame(frame), .ctl(ctl)
    );

    assign atten_code = ctl.atten;
    assign rf_sel_y   = ctl.rf_y;
    assign lo_sel_b   = ctl.lo_b;
    assign en_n       = ctl.en_n;
    assign pwr_down   = ctl.en_n | stby_pin;

    assert_pwrdn_follows_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> pwr_down);
    assert_commit_only_on_select_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> s_lvl[IDX_CSN]);
endmodule

// File: tb/sim_serial_atten_ctrl.sv
// Scoreboard bench: the driver sends frames and pushes expected states,
// and the monitor pops each one and compares it against the outputs.
module sim_serial_atten_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_csn = 1'b1;
    logic       prot_lock = 1'b0, stby_pin = 1'b0;
    logic [5:0] atten_code;
    logic       rf_sel_y, lo_sel_b, en_n, pwr_down;

    typedef struct {
        logic [5:0] atten;
        logic       rf, lo, en, pd;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    // Reference model state, written from the requirements.
    logic [5:0] m_att = 6'd51;
    logic       m_rf = 1'b0, m_lo = 1'b0, m_en = 1'b0;

    always #2 clk = ~clk;

    serial_atten_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_csn(ser_csn), .prot_lock(prot_lock), .stby_pin(stby_pin),
        .atten_code(atten_code), .rf_sel_y(rf_sel_y), .lo_sel_b(lo_sel_b),
        .en_n(en_n), .pwr_down(pwr_down)
    );

    task automatic hp();
        repeat (4) @(negedge clk);
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        e.atten = m_att; e.rf = m_rf; e.lo = m_lo; e.en = m_en;
        e.pd = m_en | stby_pin; e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic send(input logic [15:0] w, input int nclk, input logic prot, input string tag);
        logic [5:0] code;
        prot_lock = prot;
        hp();
        ser_csn = 1'b0;
        hp();
        for (int i = 0; i < nclk; i++) begin
            ser_dat = (i < 16) ? w[15-i] : 1'b0;
            hp(); ser_clk = 1'b1;
            hp(); ser_clk = 1'b0;
        end
        hp();
        ser_csn = 1'b1;
        hp();
        if (nclk == 16) begin
            code = w[6:1];
            m_att = (code > 6'd51) ? 6'd51 : code;
            if (!prot) begin
                m_rf = w[10]; m_lo = w[9]; m_en = w[8];
            end
        end
        push_exp(tag);
        prot_lock = 1'b0;
    endtask

    task automatic cmp(input logic [5:0] act, input logic [5:0] exp, input string what, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each expected item after the design has settled.
    initial begin
        forever begin
            wait (q.size() != 0);
            repeat (10) @(negedge clk);
            begin
                exp_t e;
                e = q[0];
                cmp(atten_code, e.atten, "atten_code", e.tag);
                cmp({5'd0, rf_sel_y}, {5'd0, e.rf}, "rf_sel_y", e.tag);
                cmp({5'd0, lo_sel_b}, {5'd0, e.lo}, "lo_sel_b", e.tag);
                cmp({5'd0, en_n}, {5'd0, e.en}, "en_n", e.tag);
                cmp({5'd0, pwr_down}, {5'd0, e.pd}, "pwr_down", e.tag);
                void'(q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        push_exp("R8 reset defaults");
        send(16'h0055, 16, 1'b0, "R1 R3 data 0x55 gives code 42");
        send(16'h0700, 16, 1'b0, "R5 R7 all selects set");
        send(16'hF880, 16, 1'b0, "R5 reserved A7..A3 and R3 D7 ignored");
        send(16'h04E6, 16, 1'b0, "R3 data 0xE6 max code, R5 rf Y");
        send(16'h0201, 16, 1'b0, "R3 D0 ignored, R5 lo B");
        send(16'h0067, 16, 1'b0, "R3 data 0x67 max code");
        send(16'h007E, 16, 1'b0, "R4 code 63 clamped");
        send(16'h007C, 16, 1'b0, "R4 code 62 clamped");
        send(16'h0064, 16, 1'b0, "R4 code 50 unchanged");
        send(16'h0500, 16, 1'b0, "R5 rf Y and disabled");
        send(16'h0220, 16, 1'b1, "R6 protect keeps selects, atten 16");
        send(16'h0302, 16, 1'b0, "R6 unprotected write");
        send(16'h0466, 15, 1'b0, "R2 short frame discarded");
        send(16'h0466, 17, 1'b0, "R2 long frame discarded");
        ser_csn = 1'b1;
        for (int i = 0; i < 20; i++) begin
            ser_dat = i[0];
            hp(); ser_clk = 1'b1;
            hp(); ser_clk = 1'b0;
        end
        push_exp("R1 clocks ignored while select high");
        send(16'h000A, 16, 1'b0, "R2 valid frame after aborts, code 5");
        stby_pin = 1'b1;
        push_exp("R7 standby forces power-down");
        stby_pin = 1'b0;
        push_exp("R7 standby released");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule